// File: doc/BRIEF.md
# Multi-Cycle Subset Processor Datapath

This block is the datapath half of a small load/store processor that finishes each instruction in three to five clock cycles. The supported operations are the register-to-register ALU operations (add, sub, and, or, set-less-than), word load, word store, branch-if-equal and absolute jump. A single ALU does all the arithmetic. It increments the program counter, forms branch targets, computes effective addresses and produces register results. One memory port serves both instruction fetch and data access. Values carry from one step to the next in five internal holding registers: the instruction register, the memory data register, the two operand latches and the ALU result latch. A 32-entry register file sits alongside them.

The block makes no decisions of its own. A separate sequencer watches the opcode, function field and zero flag that this block exports. Each cycle it drives one control word, which selects the multiplexers, the ALU operation and the load enables. The memory is external. It takes writes at the clock edge and returns read data for the address presented in the same cycle. The asynchronous active-low reset is released internally through a two-stage synchronizer, so the block leaves reset two clock edges after the input goes high.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held and after it is released, with no control enable asserted, the program counter holds byte address 0. This shows on `mem_addr` when the address select is 0.
- R2: A fetch cycle loads the instruction register from memory at the program counter. In the same clock edge it writes the program counter plus 4, computed by the ALU (operand A select 0 = PC, operand B select 1 = constant 4, op 010), back into the program counter (PC source 0 = ALU result).
- R3: A decode cycle latches register rs (instruction bits 25:21) into operand latch A and register rt (bits 20:16) into operand latch B. It also latches PC plus the sign-extended offset shifted left by 2 (operand B select 3) into the result latch.
- R4: ALU operation codes are 000 and, 001 or, 010 add, 110 subtract and 111 signed set-less-than, which gives 1 or 0. The zero output is high exactly when the ALU result is 0.
- R5: A register-type result is written from the result latch to register rd (bits 15:11), with the destination select set to 1 and the writeback source set to 0.
- R6: For a load, operand A plus the sign-extended offset (operand B select 2) is latched as the address. Memory at that address (address select 1) is latched into the memory data register and then written to register rt (destination select 0, writeback source 1).
- R7: For a store, operand latch B is presented on `mem_wdata` at the address held in the result latch, with `mem_we` asserted.
- R8: With conditional PC write asserted and PC source 1, the program counter loads the result latch only when the ALU subtracts B from A and the result is zero. Otherwise it keeps its value.
- R9: With PC source 2, the program counter becomes its own upper 4 bits, then instruction bits 25:0, then two zero bits.
- R10: Sign extension copies immediate bit 15 into the upper 16 bits, so negative offsets address below the base register.
- R11: Register 0 always reads as zero, and a write to it has no effect.
- R12: The program counter, instruction register, memory data register, operand latches and result latch change only on a clock edge where their own load enable is asserted.
- R13: `opcode` shows instruction register bits 31:26 and `funct` shows bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pc_we | input | 1 | Unconditional program counter load |
| ctl_pc_we_cond | input | 1 | Program counter load when ALU zero is high |
| ctl_pc_src | input | 2 | PC source: 0 ALU result, 1 result latch, 2 jump target |
| ctl_iord | input | 1 | Memory address: 0 program counter, 1 result latch |
| ctl_mem_we | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_mdr_we | input | 1 | Memory data register load |
| ctl_a_we | input | 1 | Operand latch A load |
| ctl_b_we | input | 1 | Operand latch B load |
| ctl_aluout_we | input | 1 | Result latch load |
| ctl_reg_we | input | 1 | Register file write |
| ctl_reg_dst | input | 1 | Write register: 0 rt, 1 rd |
| ctl_mem_to_reg | input | 1 | Write data: 0 result latch, 1 memory data register |
| ctl_alu_a_sel | input | 1 | ALU operand A: 0 program counter, 1 latch A |
| ctl_alu_b_sel | input | 2 | ALU operand B: 0 latch B, 1 constant 4, 2 extended offset, 3 extended offset shifted by 2 |
| ctl_alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction register bits 31:26 |
| funct | output | 6 | Instruction register bits 5:0 |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The hardest case to reach from the ports is the contents of the internal latches and the register file. None of them is visible except through the memory port. The stimulus therefore plays the role of the sequencer. It runs a real program that loads operands from memory and computes every ALU function. It then stores each result, including a value stored from register 0 after a write to it, and a store through a negative offset. A taken branch and a jump skip over instructions. This placement is checked by comparing each fetch address with an independently tracked program counter. The stimulus also inserts a cycle with every enable low between decode and store, which shows that nothing moves without its enable.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;
  localparam int JT_W    = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int OPC_LSB = 26;
  localparam int PAGE_W  = 4;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    PCN_ALU    = 2'd0,
    PCN_ALUOUT = 2'd1,
    PCN_JUMP   = 2'd2
  } pc_src_e;

  typedef enum logic [1:0] {
    OPB_REG    = 2'd0,
    OPB_FOUR   = 2'd1,
    OPB_IMM    = 2'd2,
    OPB_IMM_SH = 2'd3
  } opb_sel_e;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         zero
);

  logic [W-1:0] diff;

  always_comb begin
    diff = opa - opb;
    case (alu_op_e'(op))
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = diff;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mc_opsel.sv
module mc_opsel
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             a_sel,
  input  logic [1:0]       b_sel,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     a_q,
  input  logic [W-1:0]     b_q,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     opa,
  output logic [W-1:0]     opb
);

  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    opa = a_sel ? a_q : pc;
    case (opb_sel_e'(b_sel))
      OPB_REG:    opb = b_q;
      OPB_FOUR:   opb = W'(4);
      OPB_IMM:    opb = imm_ext;
      OPB_IMM_SH: opb = imm_ext << 2;
      default:    opb = b_q;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0]  store [NREG];
  logic [AW-1:0] raddr [2];
  logic [W-1:0]  rdata [2];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store[waddr] <= wdata;
  end

  assign raddr[0] = raddr_a;
  assign raddr[1] = raddr_b;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : store[raddr[p]];
    end
  endgenerate

  assign rdata_a = rdata[0];
  assign rdata_b = rdata[1];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_pc_we,
  input  logic            ctl_pc_we_cond,
  input  logic [1:0]      ctl_pc_src,
  input  logic            ctl_iord,
  input  logic            ctl_mem_we,
  input  logic            ctl_ir_we,
  input  logic            ctl_mdr_we,
  input  logic            ctl_a_we,
  input  logic            ctl_b_we,
  input  logic            ctl_aluout_we,
  input  logic            ctl_reg_we,
  input  logic            ctl_reg_dst,
  input  logic            ctl_mem_to_reg,
  input  logic            ctl_alu_a_sel,
  input  logic [1:0]      ctl_alu_b_sel,
  input  logic [2:0]      ctl_alu_op,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            alu_zero
);

  localparam int AW = $clog2(NREG);
  localparam int LOW_W = XLEN - PAGE_W;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // holding registers
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] mdr_q, mdr_d;
  logic [XLEN-1:0] a_q, a_d;
  logic [XLEN-1:0] b_q, b_d;
  logic [XLEN-1:0] aluout_q, aluout_d;

  logic [XLEN-1:0] rf_a, rf_b, rf_wdata;
  logic [AW-1:0]   rs_f, rt_f, rd_f, rf_waddr;
  logic [XLEN-1:0] alu_a, alu_b, alu_res;
  logic [XLEN-1:0] jump_tgt;
  logic            pc_load;

  assign rs_f = ir_q[RS_LSB +: AW];
  assign rt_f = ir_q[RT_LSB +: AW];
  assign rd_f = ir_q[RD_LSB +: AW];

  assign jump_tgt = {pc_q[XLEN-1 -: PAGE_W], ir_q[JT_W-1:0], 2'b00};

  mc_opsel #(.W(XLEN)) u_opsel (
    .a_sel (ctl_alu_a_sel),
    .b_sel (ctl_alu_b_sel),
    .pc    (pc_q),
    .a_q   (a_q),
    .b_q   (b_q),
    .imm   (ir_q[IMM_W-1:0]),
    .opa   (alu_a),
    .opb   (alu_b)
  );

  mc_alu #(.W(XLEN)) u_alu (
    .op   (ctl_alu_op),
    .opa  (alu_a),
    .opb  (alu_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  assign rf_waddr = ctl_reg_dst ? rd_f : rt_f;
  assign rf_wdata = ctl_mem_to_reg ? mdr_q : aluout_q;

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (ctl_reg_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  // next-state
  assign pc_load = ctl_pc_we | (ctl_pc_we_cond & alu_zero);

  always_comb begin
    pc_d = pc_q;
    if (pc_load) begin
      case (pc_src_e'(ctl_pc_src))
        PCN_ALU:    pc_d = alu_res;
        PCN_ALUOUT: pc_d = aluout_q;
        PCN_JUMP:   pc_d = jump_tgt;
        default:    pc_d = pc_q;
      endcase
    end
    ir_d     = ctl_ir_we     ? mem_rdata : ir_q;
    mdr_d    = ctl_mdr_we    ? mem_rdata : mdr_q;
    a_d      = ctl_a_we      ? rf_a      : a_q;
    b_d      = ctl_b_we      ? rf_b      : b_q;
    aluout_d = ctl_aluout_we ? alu_res   : aluout_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      pc_q     <= pc_d;
      ir_q     <= ir_d;
      mdr_q    <= mdr_d;
      a_q      <= a_d;
      b_q      <= b_d;
      aluout_q <= aluout_d;
    end
  end

  assign mem_addr  = ctl_iord ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl_mem_we;
  assign opcode    = ir_q[OPC_LSB +: OPC_W];
  assign funct     = ir_q[FN_W-1:0];

  // R2
  fetch_incr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_pc_we && ctl_pc_src == PCN_ALU && !ctl_alu_a_sel &&
     ctl_alu_b_sel == OPB_FOUR && ctl_alu_op == ALU_ADD)
    |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R4
  sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_alu_op == ALU_SUB) |-> (alu_zero == (alu_a == alu_b)));

  // R8
  beq_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_pc_we_cond && !ctl_pc_we && !alu_zero) |=> $stable(pc_q));

  // R9
  jump_page_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_pc_we && ctl_pc_src == PCN_JUMP)
    |=> (pc_q[1:0] == 2'b00 &&
         pc_q[XLEN-1 -: PAGE_W] == $past(pc_q[XLEN-1 -: PAGE_W])));

  // R12
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctl_pc_we && !ctl_pc_we_cond) |=> $stable(pc_q));

  // R12
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_ir_we |=> $stable(ir_q));

  // R12
  aluout_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_aluout_we |=> $stable(aluout_q));

  // R13
  opcode_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_ir_we |=> (opcode == $past(mem_rdata[31:26])));

  // The low bits of the PC are compared to keep LOW_W in use for wide builds.
  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_pc_we && ctl_pc_src == PCN_JUMP) |=> (pc_q[LOW_W-1:0] % 4 == 0));

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        c_pc_we, c_pc_we_cond, c_iord, c_mem_we, c_ir_we, c_mdr_we;
  logic        c_a_we, c_b_we, c_aluout_we, c_reg_we, c_reg_dst, c_mem_to_reg, c_a_sel;
  logic [1:0]  c_pc_src, c_b_sel;
  logic [2:0]  c_alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, alu_zero;
  logic [5:0]  opcode, funct;

  logic [31:0] mem [64];
  logic [31:0] model_rf [32];
  logic [31:0] exp_pc;
  logic [63:0] exp_q [$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign mem_rdata = mem[mem_addr[7:2]];

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n),
    .ctl_pc_we(c_pc_we), .ctl_pc_we_cond(c_pc_we_cond), .ctl_pc_src(c_pc_src),
    .ctl_iord(c_iord), .ctl_mem_we(c_mem_we), .ctl_ir_we(c_ir_we),
    .ctl_mdr_we(c_mdr_we), .ctl_a_we(c_a_we), .ctl_b_we(c_b_we),
    .ctl_aluout_we(c_aluout_we), .ctl_reg_we(c_reg_we), .ctl_reg_dst(c_reg_dst),
    .ctl_mem_to_reg(c_mem_to_reg), .ctl_alu_a_sel(c_a_sel), .ctl_alu_b_sel(c_b_sel),
    .ctl_alu_op(c_alu_op), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .opcode(opcode), .funct(funct),
    .alu_zero(alu_zero)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_ctl();
    {c_pc_we, c_pc_we_cond, c_iord, c_mem_we, c_ir_we, c_mdr_we} = '0;
    {c_a_we, c_b_we, c_aluout_we, c_reg_we, c_reg_dst, c_mem_to_reg, c_a_sel} = '0;
    c_pc_src = 2'd0; c_b_sel = 2'd0; c_alu_op = 3'b010;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clear_ctl();
  endtask

  // scoreboard monitor: memory writes (R7)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected write actual=%0h/%0h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          errors++;
          $display("FAIL R7: store actual=%0h/%0h expected=%0h/%0h",
                   mem_addr, mem_wdata, e[63:32], e[31:0]);
        end
      end
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [2:0] fn_to_op(logic [5:0] fn);
    case (fn)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      default:   return 3'b111;
    endcase
  endfunction

  function automatic logic [31:0] model_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      default:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  // one instruction, driven as the sequencer would
  task automatic run(input bit hold_test);
    logic [31:0] ins, sx, ea;
    int rs, rt, rd;
    // fetch (R2)
    c_ir_we = 1; c_pc_we = 1; c_b_sel = 2'd1; c_alu_op = 3'b010;
    #1 check("R2 fetch address", mem_addr, exp_pc);
    ins = mem[exp_pc[7:2]];
    tick();
    exp_pc = exp_pc + 4;
    check("R13 opcode", opcode, ins[31:26]);
    check("R13 funct", funct, ins[5:0]);
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};   // R10
    // decode (R3)
    c_a_we = 1; c_b_we = 1; c_aluout_we = 1; c_b_sel = 2'd3;
    tick();
    if (hold_test) begin
      // R12: no enables for one cycle; PC and IR must not move
      #1 check("R12 pc held", mem_addr, exp_pc);
      tick();
      check("R12 ir held", opcode, ins[31:26]);
    end
    case (ins[31:26])
      6'b000000: begin
        c_a_sel = 1; c_b_sel = 2'd0; c_alu_op = fn_to_op(ins[5:0]); c_aluout_we = 1;
        tick();
        c_reg_we = 1; c_reg_dst = 1; c_mem_to_reg = 0;   // R5
        tick();
        if (rd != 0) model_rf[rd] = model_alu(ins[5:0], model_rf[rs], model_rf[rt]);
      end
      6'b100011: begin                                  // R6
        c_a_sel = 1; c_b_sel = 2'd2; c_aluout_we = 1;
        tick();
        ea = model_rf[rs] + sx;
        c_iord = 1; c_mdr_we = 1;
        #1 check("R6 load address", mem_addr, ea);
        tick();
        c_reg_we = 1; c_reg_dst = 0; c_mem_to_reg = 1;
        tick();
        if (rt != 0) model_rf[rt] = mem[ea[7:2]];
      end
      6'b101011: begin                                  // R7
        c_a_sel = 1; c_b_sel = 2'd2; c_aluout_we = 1;
        tick();
        ea = model_rf[rs] + sx;
        exp_q.push_back({ea, model_rf[rt]});
        c_iord = 1; c_mem_we = 1;
        @(posedge clk); mem[ea[7:2]] = mem_wdata; #1;
        clear_ctl();
      end
      6'b000100: begin                                  // R8
        c_a_sel = 1; c_b_sel = 2'd0; c_alu_op = 3'b110; c_pc_we_cond = 1; c_pc_src = 2'd1;
        #1 check("R4 zero flag", alu_zero, model_rf[rs] == model_rf[rt]);
        tick();
        if (model_rf[rs] == model_rf[rt]) exp_pc = exp_pc + (sx << 2);
      end
      default: begin                                    // R9
        c_pc_we = 1; c_pc_src = 2'd2;
        tick();
        exp_pc = {exp_pc[31:28], ins[25:0], 2'b00};
      end
    endcase
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    model_rf[0] = 0;
    mem[0]  = enc_i(6'b100011, 0, 1, 16'h0080);
    mem[1]  = enc_i(6'b100011, 0, 2, 16'h0084);
    mem[2]  = enc_i(6'b100011, 0, 9, 16'h0088);
    mem[3]  = enc_r(1, 2, 3, 6'b100000);
    mem[4]  = enc_r(1, 2, 4, 6'b100010);
    mem[5]  = enc_r(1, 2, 5, 6'b100100);
    mem[6]  = enc_r(1, 2, 6, 6'b100101);
    mem[7]  = enc_r(2, 1, 7, 6'b101010);
    mem[8]  = enc_r(1, 2, 8, 6'b101010);
    mem[9]  = enc_r(1, 1, 0, 6'b100000);
    mem[10] = enc_i(6'b000100, 1, 2, 16'h0005);
    mem[11] = enc_i(6'b000100, 3, 3, 16'h0002);
    mem[12] = enc_i(6'b101011, 0, 1, 16'h00A0);
    mem[13] = enc_i(6'b101011, 0, 1, 16'h00A0);
    mem[14] = {6'b000010, 26'h18};
    mem[24] = enc_i(6'b101011, 0, 3, 16'h0090);
    mem[25] = enc_i(6'b101011, 0, 4, 16'h0094);
    mem[26] = enc_i(6'b101011, 0, 5, 16'h0098);
    mem[27] = enc_i(6'b101011, 0, 6, 16'h009C);
    mem[28] = enc_i(6'b101011, 0, 7, 16'h00A0);
    mem[29] = enc_i(6'b101011, 0, 8, 16'h00A4);
    mem[30] = enc_i(6'b101011, 0, 0, 16'h00A8);
    mem[31] = enc_i(6'b101011, 9, 1, 16'hFFFC);
    mem[32] = 32'h0000_0007;
    mem[33] = 32'hFFFF_FFFD;
    mem[34] = 32'h0000_00B0;
    clear_ctl();
    repeat (3) @(posedge clk);
    #1 check("R1 pc in reset", mem_addr, 32'h0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 pc after reset", mem_addr, 32'h0);
    exp_pc = 0;
    // 0x00..0x24: loads, ALU ops, write to register 0 (R11)
    for (int k = 0; k < 10; k++) run(0);
    run(0);                 // beq not taken
    run(0);                 // beq taken, skips 0x30/0x34
    check("R8 branch target", exp_pc, 32'h38);
    run(0);                 // jump to 0x60 (R9)
    check("R9 jump target", exp_pc, 32'h60);
    run(1);                 // store 4 with idle hold cycle (R12, R3)
    for (int k = 0; k < 5; k++) run(0);
    run(0);                 // store of register 0 gives 0 (R11)
    run(0);                 // negative offset store to 0xAC (R10)
    #1 check("R2 final pc", mem_addr, 32'h80);
    check("R7 all stores seen", exp_q.size(), 0);
    check("R4 and result", mem[38], 32'h5);
    check("R4 slt result", mem[40], 32'h1);
    check("R11 r0 stored", mem[42], 32'h0);
    check("R10 neg offset", mem[43], 32'h7);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule